// File: doc/BRIEF.md
# I2C Register-Write Target with Multi-Byte Registers

This block is a write-only I2C target that loads a small register bank through an 8-bit subaddress. It oversamples the bus lines on a fast system clock. It detects start and stop conditions, matches its own 7-bit device address and acknowledges each byte by pulling SDA low. It then builds each register value from the data bytes that follow.

Registers are one to four bytes wide, and the width depends on the subaddress. Bytes collect in a staging register, most significant byte first. The bank sees a single write strobe only when the last byte of a register arrives. After each committed register the subaddress advances by one, so a controller can fill a run of consecutive registers in one transaction. Bytes of a trailing register that is still incomplete at a stop or repeated start are dropped. Registers completed earlier in the same transaction remain written.

Top module: `i2c_regwr_target`

## Requirements
- R1: While and directly after reset, the SDA pull output is released and no write strobe is issued.
- R2: After a start, the target acknowledges (pulls SDA low during the ninth SCL pulse) when the first byte equals the device address followed by a 0 in the least significant bit.
- R3: When the first byte carries a different address or a 1 in the least significant bit, the target acknowledges neither that byte nor any later byte, and issues no write until the next start.
- R4: Within an addressed write, the target acknowledges the subaddress byte and every data byte. Every byte is received most significant bit first.
- R5: A register at subaddress S is W bytes wide, where W is S bits [1:0] plus one. After its W-th data byte, the target issues exactly one strobe. It carries address S and the W bytes concatenated first-byte-most-significant, right-aligned and zero-extended in a 32-bit word.
- R6: After each commit, the subaddress becomes S+1 (modulo 256) and the byte count restarts at the width of S+1.
- R7: At a stop, bytes of an incomplete trailing register are discarded, and registers committed earlier in the transaction stay written.
- R8: At a repeated start, bytes of an incomplete register are discarded and the new transaction is handled from its device address.
- R9: One transaction can write 16 consecutive registers, and all 16 are committed in subaddress order.
- R10: The write strobe lasts one clock per commit, and no strobe occurs without a completed register.
- R11: The SDA pull output changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_i | input | 1 | SDA line level, asynchronous |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_en_o | output | 1 | Register write strobe, one clock |
| wr_addr_o | output | 8 | Subaddress of the committed register |
| wr_data_o | output | 32 | Committed value, right-aligned |

## Verification
The hardest case to reach is the boundary between committed and dropped state. A register must be cut off after some of its bytes, right behind other registers in the same transaction that already committed. This must happen once at a stop and once at a repeated start, and the following transaction must then start cleanly. The bench reaches it by driving sequential transactions whose byte counts stop short of the width sum. Its own width model forecasts exactly which registers commit, and the scoreboard flags any extra or missing strobe. A 16-register run covers all four widths and all their transitions.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
  localparam int SUB_W   = 8;
  localparam int MAX_B   = 4;
  localparam int CNT_W   = $clog2(MAX_B + 1);
  localparam int VAL_W   = MAX_B * 8;

  typedef enum logic [1:0] {
    E_IDLE,
    E_RX,
    E_ACK,
    E_IGN
  } eng_state_t;

  // register width in bytes: low two subaddress bits plus one
  function automatic logic [CNT_W-1:0] reg_bytes(input logic [SUB_W-1:0] sub);
    reg_bytes = CNT_W'(sub[1:0]) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_prev, sda_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else if (g == 0) begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_pipe[STAGES-1];
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_pipe[STAGES-1];
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_regwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2D
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       sda_pull,
  output logic       sub_ev,
  output logic       dat_ev,
  output logic [7:0] byte_q
);
  localparam int BIT_W = 3;

  eng_state_t       state;
  logic [BIT_W-1:0] bit_cnt;
  logic [1:0]       byte_idx;   // 0 device, 1 subaddress, 2 data
  logic [7:0]       shreg;
  logic             ack_pend;
  logic [7:0]       nxt;

  assign nxt = {shreg[6:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= E_IDLE;
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      byte_q   <= '0;
      ack_pend <= 1'b0;
      sda_pull <= 1'b0;
      sub_ev   <= 1'b0;
      dat_ev   <= 1'b0;
    end else begin
      sub_ev <= 1'b0;
      dat_ev <= 1'b0;
      if (start_det) begin
        state    <= E_RX;
        bit_cnt  <= '0;
        byte_idx <= '0;
        ack_pend <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= E_IDLE;
        ack_pend <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          E_RX: begin
            if (scl_rise) begin
              shreg <= nxt;
              if (bit_cnt == BIT_W'(7)) begin
                bit_cnt <= '0;
                byte_q  <= nxt;
                if (byte_idx == 2'd0) begin
                  if (nxt == {DEV_ADDR, 1'b0}) ack_pend <= 1'b1;
                  else state <= E_IGN;
                end else begin
                  ack_pend <= 1'b1;
                  if (byte_idx == 2'd1) sub_ev <= 1'b1;
                  else dat_ev <= 1'b1;
                end
              end else begin
                bit_cnt <= bit_cnt + BIT_W'(1);
              end
            end else if (scl_fall && ack_pend) begin
              sda_pull <= 1'b1;
              ack_pend <= 1'b0;
              state    <= E_ACK;
            end
          end
          E_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= E_RX;
              if (byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // pull line may only move while SCL is low
  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_s));

  // ignored transactions stay silent
  p_ign_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (state == E_IGN) |-> !sda_pull);

  // no byte events while ignoring
  p_ign_no_event_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == E_IGN && !$past(start_det)) |-> !(sub_ev || dat_ev));
endmodule

// File: rtl/i2c_reg_stage.sv
module i2c_reg_stage
  import i2c_regwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sub_ev,
  input  logic             dat_ev,
  input  logic [7:0]       byte_i,
  output logic             wr_en,
  output logic [SUB_W-1:0] wr_addr,
  output logic [VAL_W-1:0] wr_data
);
  logic [SUB_W-1:0] sub_q;
  logic [CNT_W-1:0] rem_q;
  logic [VAL_W-1:0] stage_q;
  logic             armed_q;
  logic [VAL_W-1:0] merged;

  assign merged = {stage_q[VAL_W-9:0], byte_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q   <= '0;
      rem_q   <= '0;
      stage_q <= '0;
      armed_q <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (clr) begin
        armed_q <= 1'b0;
        stage_q <= '0;
      end else if (sub_ev) begin
        sub_q   <= byte_i;
        rem_q   <= reg_bytes(byte_i);
        stage_q <= '0;
        armed_q <= 1'b1;
      end else if (dat_ev && armed_q) begin
        if (rem_q == CNT_W'(1)) begin
          wr_en   <= 1'b1;
          wr_addr <= sub_q;
          wr_data <= merged;
          sub_q   <= sub_q + SUB_W'(1);
          rem_q   <= reg_bytes(sub_q + SUB_W'(1));
          stage_q <= '0;
        end else begin
          rem_q   <= rem_q - CNT_W'(1);
          stage_q <= merged;
        end
      end
    end
  end

  p_single_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_next_sub_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (sub_q == wr_addr + SUB_W'(1)));

  p_rem_range_r5: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (rem_q >= CNT_W'(1) && rem_q <= CNT_W'(MAX_B)));
endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
  import i2c_regwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2D,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  output logic        wr_en_o,
  output logic [7:0]  wr_addr_o,
  output logic [31:0] wr_data_o
);
  logic scl_s, scl_rise, scl_fall, start_det, stop_det;
  logic sda_s_raw;
  logic sub_ev, dat_ev;
  logic [7:0] byte_q;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // second sampled copy of SDA for the byte shifter
  logic [SYNC_STAGES-1:0] sda_pipe;
  always_ff @(posedge clk) begin
    if (rst) sda_pipe <= '1;
    else     sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
  end
  assign sda_s_raw = sda_pipe[SYNC_STAGES-1];

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s_raw),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull_o),
    .sub_ev    (sub_ev),
    .dat_ev    (dat_ev),
    .byte_q    (byte_q)
  );

  i2c_reg_stage u_stage (
    .clk     (clk),
    .rst     (rst),
    .clr     (start_det | stop_det),
    .sub_ev  (sub_ev),
    .dat_ev  (dat_ev),
    .byte_i  (byte_q),
    .wr_en   (wr_en_o),
    .wr_addr (wr_addr_o),
    .wr_data (wr_data_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_en_o && !sda_pull_o));
endmodule

// File: tb/i2c_regwr_target_tb.sv
module i2c_regwr_target_tb;
  localparam int         CLK_PERIOD = 10;
  localparam int         QTR        = 4;
  localparam logic [6:0] DEV        = 7'h2D;
  localparam int         WDOG_MAX   = 150000;

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] d;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull_o, wr_en_o;
  logic [7:0] wr_addr_o;
  logic [31:0] wr_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t exp_q[$];
  logic [7:0] tx [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_pull_o;

  i2c_regwr_target #(.DEV_ADDR(DEV)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  function automatic int width_of(input logic [7:0] s);
    return int'(s[1:0]) + 1;
  endfunction

  // scoreboard monitor (R5, R10)
  always @(negedge clk) begin
    if (!rst && wr_en_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected strobe addr=%02h data=%08h expected none",
                 wr_addr_o, wr_data_o);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (e.a !== wr_addr_o || e.d !== wr_data_o) begin
          errors++;
          $display("FAIL R5 commit actual %02h/%08h expected %02h/%08h",
                   wr_addr_o, wr_data_o, e.a, e.d);
        end
      end
    end
  end

  // R11: pull output must not move while bench SCL is high
  logic prev_pull = 1'b0;
  int r11_bad = 0;
  always @(negedge clk) begin
    if (!rst && sda_pull_o !== prev_pull && scl) r11_bad++;
    prev_pull <= sda_pull_o;
  end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(QTR);
    scl = 1'b1;   wclk(QTR);
    sda_m = 1'b0; wclk(QTR);
    scl = 1'b0;   wclk(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(QTR);
    scl = 1'b1;   wclk(QTR);
    sda_m = 1'b1; wclk(2*QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(2*QTR);
      scl = 1'b1;   wclk(2*QTR);
      scl = 1'b0;
    end
    sda_m = 1'b1; wclk(2*QTR);
    scl = 1'b1;   wclk(QTR);
    @(negedge clk);
    got = ~sda_line;
    wclk(QTR);
    scl = 1'b0;   wclk(2*QTR);
    check(got == exp_ack, req, int'(got), int'(exp_ack));
  endtask

  // one transaction: device byte, subaddress, n data bytes from tx[]
  task automatic xfer(input logic [7:0] dev, input logic [7:0] sub, input int n,
                      input bit end_stop, input string req);
    bit ok;
    logic [7:0] cur;
    int rem;
    logic [31:0] acc;
    ok = (dev == {DEV, 1'b0});
    if (ok) begin
      cur = sub; rem = width_of(cur); acc = '0;
      for (int i = 0; i < n; i++) begin
        acc = (acc << 8) | 32'(tx[i]);
        rem--;
        if (rem == 0) begin
          exp_q.push_back('{a: cur, d: acc});
          cur = cur + 8'd1; rem = width_of(cur); acc = '0;
        end
      end
    end
    bus_start();
    send_byte(dev, ok, ok ? "R2 device ack" : "R3 no ack on device");
    send_byte(sub, ok, ok ? "R4 subaddress ack" : "R3 no ack on subaddress");
    for (int i = 0; i < n; i++)
      send_byte(tx[i], ok, ok ? "R4 data ack" : "R3 no ack on data");
    if (end_stop) begin
      bus_stop();
      wclk(8);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
    end
  endtask

  initial begin
    for (int c = 0; c < WDOG_MAX; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wclk(4);
    @(negedge clk);
    check(sda_pull_o == 1'b0, "R1 pull released in reset", sda_pull_o, 0);
    check(wr_en_o == 1'b0, "R1 no strobe in reset", wr_en_o, 0);
    rst = 1'b0;
    wclk(4);
    @(negedge clk);
    check(sda_pull_o == 1'b0 && wr_en_o == 1'b0, "R1 idle after reset",
          {sda_pull_o, wr_en_o}, 0);

    // R5: 1-byte register
    tx[0] = 8'h5A;
    xfer({DEV, 1'b0}, 8'h10, 1, 1'b1, "R5 single byte commit");

    // R5: 4-byte register, MSB byte first
    tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; tx[3] = 8'h44;
    xfer({DEV, 1'b0}, 8'h13, 4, 1'b1, "R5 four byte commit");

    // R6/R7: 0x06(3) 0x07(4) 0x08(1) then 1 of 0x09(2) dropped at stop
    for (int i = 0; i < 9; i++) tx[i] = 8'(8'hA0 + i);
    xfer({DEV, 1'b0}, 8'h06, 9, 1'b1, "R6 R7 sequential with partial tail");

    // R3: wrong address, then read bit
    for (int i = 0; i < 3; i++) tx[i] = 8'hFF;
    xfer({7'h2C, 1'b0}, 8'h01, 3, 1'b1, "R3 wrong address ignored");
    xfer({DEV, 1'b1}, 8'h00, 1, 1'b1, "R3 read bit ignored");

    // R8: partial register cut by repeated start
    tx[0] = 8'hEE;
    xfer({DEV, 1'b0}, 8'h21, 1, 1'b0, "R8");
    tx[0] = 8'hAA;
    xfer({DEV, 1'b0}, 8'h30, 1, 1'b1, "R8 partial dropped at repeated start");

    // R9: 16 consecutive registers 0x40..0x4F (40 bytes)
    for (int i = 0; i < 40; i++) tx[i] = 8'(8'h07 * i + 8'h31);
    xfer({DEV, 1'b0}, 8'h40, 40, 1'b1, "R9 sixteen registers");

    // R6: wrap from 0xFF (4 bytes) to 0x00 (1 byte)
    tx[0] = 8'hDE; tx[1] = 8'hAD; tx[2] = 8'hBE; tx[3] = 8'hEF; tx[4] = 8'h77;
    xfer({DEV, 1'b0}, 8'hFF, 5, 1'b1, "R6 subaddress wrap");

    wclk(10);
    check(r11_bad == 0, "R11 pull changes only with SCL low", r11_bad, 0);
    check(exp_q.size() == 0, "R10 no missing strobes", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule